// File: doc/BRIEF.md
# Strided Gap-Skipping Copy Engine

This block is a register-programmed memory-to-memory mover. Software loads a source base, a destination base, a total byte count and two geometry words, then writes a start register. The engine walks the source as rows of a programmable width separated by a skipped gap. It lays the bytes into the destination using a second, independent width and gap. Data can therefore be repacked between two layouts with different padding, and row ends on the two sides need not coincide.

Data moves in 16-byte beats over a 128-bit path. Each beat is read from the source cursor and written one cycle later to the destination cursor. A byte strobe trims the final beat when the byte count is not a multiple of 16. A level interrupt reports completion and stays high until software clears it.

Top module: `strided_copy_engine`

## Requirements
- R1: Register word offsets are 0 source base, 1 destination base, 2 byte count, 3 source geometry, 4 destination geometry, 5 control, 6 start, 7 status. Both base registers hold a byte address shifted right by 3, and the engine uses the value shifted left by 3.
- R2: In a geometry word, bits 15:0 give the row width and bits 31:16 give the gap. Both count 16-byte units.
- R3: Each beat issues a 16-byte read at the source cursor, and the read data returns on the next cycle. The matching write to the destination cursor comes exactly one cycle after its read. Reads are issued on back-to-back cycles until the count is exhausted.
- R4: On each side, after width bytes have been consumed, the cursor skips gap bytes and starts a new row. The two sides wrap independently, and the destination receives the source bytes in order.
- R5: The transfer moves exactly the byte count. On the final beat, strobe bit i enables byte address+i, and only the low (count mod 16) bytes are enabled when the count is not a multiple of 16.
- R6: A write to the start register begins a transfer only when control bit 3 is set. Otherwise the write is ignored.
- R7: busy rises on the edge that accepts the start and stays high until completion. A start write while busy is ignored and adds no accesses.
- R8: On completion, busy falls and irq rises on the same edge, one cycle after the final write.
- R9: A start with a byte count of zero, a zero source width or a zero destination width raises irq on the accepting edge. In that case busy stays low and no memory access is made.
- R10: irq is a level that holds until a status write with bit 0 set. A status write with bit 0 clear has no effect on it.
- R11: After reset, busy, irq, mem_rd_en and mem_wr_en are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Completion interrupt, level |
| mem_rd_en | output | 1 | Read request for one beat |
| mem_rd_addr | output | 32 | Byte address of the beat read |
| mem_rd_data | input | 128 | Read data, valid the cycle after mem_rd_en |
| mem_wr_en | output | 1 | Write request for one beat |
| mem_wr_addr | output | 32 | Byte address of the beat write |
| mem_wr_data | output | 128 | Write data |
| mem_wr_strb | output | 16 | Per-byte write enable |

## Verification
The bench aims at mismatched row geometry, where a destination row ends in the middle of a source row. A design that reloaded both cursors together, or that added a gap on the wrong side, would write bytes into the padding or drop them. Under such a fault the whole-memory comparison shows damaged gaps. A count that is not a multiple of 16 exercises the trimmed strobe, and an engine that wrote the whole last beat would overwrite the bytes that follow. The bench also issues zero-length jobs, a start with the mode bit clear and a second start while busy. A design that touched memory, ran the job twice or never raised irq in these cases is caught by the per-clock transaction comparison.

// File: rtl/strided_copy_pkg.sv
package strided_copy_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } seq_state_e;

    // register word offsets
    localparam int OFS_SRC_BASE = 0;
    localparam int OFS_DST_BASE = 1;
    localparam int OFS_COUNT    = 2;
    localparam int OFS_SRC_GEOM = 3;
    localparam int OFS_DST_GEOM = 4;
    localparam int OFS_CTRL     = 5;
    localparam int OFS_START    = 6;
    localparam int OFS_STATUS   = 7;

    localparam int CTRL_MODE_BIT = 3;
    localparam int BASE_SHIFT    = 3;
    localparam int GEOM_SHIFT    = 4;

    typedef struct packed {
        logic [31:0] src_word;
        logic [31:0] dst_word;
        logic [31:0] count;
        logic [31:0] src_geom;
        logic [31:0] dst_geom;
        logic [31:0] ctrl;
    } cfg_regs_t;

endpackage

// File: rtl/strided_copy_regs.sv
module strided_copy_regs
    import strided_copy_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int REG_AW = 3,
    parameter int GEOM_W = 16,
    localparam int LEN_W = GEOM_W + GEOM_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [ADDR_W-1:0] base_o  [2],
    output logic [LEN_W-1:0]  width_o [2],
    output logic [LEN_W-1:0]  gap_o   [2],
    output logic [31:0]       count_o,
    output logic              mode_en_o,
    output logic              start_o,
    output logic              irq_clr_o
);

    cfg_regs_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_we) begin
            case (reg_addr)
                REG_AW'(OFS_SRC_BASE): cfg_d.src_word = reg_wdata;
                REG_AW'(OFS_DST_BASE): cfg_d.dst_word = reg_wdata;
                REG_AW'(OFS_COUNT):    cfg_d.count    = reg_wdata;
                REG_AW'(OFS_SRC_GEOM): cfg_d.src_geom = reg_wdata;
                REG_AW'(OFS_DST_GEOM): cfg_d.dst_geom = reg_wdata;
                REG_AW'(OFS_CTRL):     cfg_d.ctrl     = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        base_o[0]  = ADDR_W'(cfg_q.src_word) << BASE_SHIFT;
        base_o[1]  = ADDR_W'(cfg_q.dst_word) << BASE_SHIFT;
        width_o[0] = LEN_W'(cfg_q.src_geom[GEOM_W-1:0]) << GEOM_SHIFT;
        width_o[1] = LEN_W'(cfg_q.dst_geom[GEOM_W-1:0]) << GEOM_SHIFT;
        gap_o[0]   = LEN_W'(cfg_q.src_geom[2*GEOM_W-1:GEOM_W]) << GEOM_SHIFT;
        gap_o[1]   = LEN_W'(cfg_q.dst_geom[2*GEOM_W-1:GEOM_W]) << GEOM_SHIFT;
        count_o    = cfg_q.count;
        mode_en_o  = cfg_q.ctrl[CTRL_MODE_BIT];
        start_o    = reg_we && (reg_addr == REG_AW'(OFS_START));
        irq_clr_o  = reg_we && (reg_addr == REG_AW'(OFS_STATUS)) && reg_wdata[0];
    end

endmodule

// File: rtl/strided_copy_cursor.sv
module strided_copy_cursor #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 20,
    parameter int BEAT_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  width,
    input  logic [LEN_W-1:0]  gap,
    output logic [ADDR_W-1:0] addr
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  left;
    } cur_t;

    cur_t cur_d, cur_q;

    always_comb begin
        cur_d = cur_q;
        if (load) begin
            cur_d.addr = base;
            cur_d.left = width;
        end else if (step) begin
            if (cur_q.left <= LEN_W'(BEAT_BYTES)) begin
                cur_d.left = width;
                cur_d.addr = cur_q.addr + ADDR_W'(BEAT_BYTES) + ADDR_W'(gap);
            end else begin
                cur_d.left = cur_q.left - LEN_W'(BEAT_BYTES);
                cur_d.addr = cur_q.addr + ADDR_W'(BEAT_BYTES);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    assign addr = cur_q.addr;

    // R4
    row_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |-> (cur_q.left != '0));

endmodule

// File: rtl/strided_copy_engine.sv
module strided_copy_engine
    import strided_copy_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 128,
    parameter int REG_AW = 3,
    parameter int GEOM_W = 16,
    localparam int BEAT_BYTES = DATA_W / 8,
    localparam int LEN_W      = GEOM_W + GEOM_SHIFT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [REG_AW-1:0]     reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic                  busy,
    output logic                  irq,
    output logic                  mem_rd_en,
    output logic [ADDR_W-1:0]     mem_rd_addr,
    input  logic [DATA_W-1:0]     mem_rd_data,
    output logic                  mem_wr_en,
    output logic [ADDR_W-1:0]     mem_wr_addr,
    output logic [DATA_W-1:0]     mem_wr_data,
    output logic [BEAT_BYTES-1:0] mem_wr_strb
);

    typedef struct packed {
        seq_state_e            state;
        logic [31:0]           left;
        logic                  wr_en;
        logic [ADDR_W-1:0]     wr_addr;
        logic [BEAT_BYTES-1:0] wr_strb;
        logic                  irq;
    } seq_t;

    logic [ADDR_W-1:0] side_base  [2];
    logic [LEN_W-1:0]  side_width [2];
    logic [LEN_W-1:0]  side_gap   [2];
    logic [ADDR_W-1:0] side_addr  [2];
    logic [31:0]       count;
    logic              mode_en, start_req, irq_clr;
    logic              cur_load, cur_step;

    strided_copy_regs #(
        .ADDR_W (ADDR_W),
        .REG_AW (REG_AW),
        .GEOM_W (GEOM_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .base_o    (side_base),
        .width_o   (side_width),
        .gap_o     (side_gap),
        .count_o   (count),
        .mode_en_o (mode_en),
        .start_o   (start_req),
        .irq_clr_o (irq_clr)
    );

    // side 0 walks the source, side 1 walks the destination
    for (genvar g = 0; g < 2; g++) begin : g_side
        strided_copy_cursor #(
            .ADDR_W     (ADDR_W),
            .LEN_W      (LEN_W),
            .BEAT_BYTES (BEAT_BYTES)
        ) u_cursor (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (cur_load),
            .step  (cur_step),
            .base  (side_base[g]),
            .width (side_width[g]),
            .gap   (side_gap[g]),
            .addr  (side_addr[g])
        );
    end

    seq_t seq_d, seq_q;
    logic irq_set;
    logic empty_job;

    always_comb begin
        seq_d       = seq_q;
        seq_d.wr_en = 1'b0;
        cur_load    = 1'b0;
        cur_step    = 1'b0;
        mem_rd_en   = 1'b0;
        irq_set     = 1'b0;
        empty_job   = (count == '0) || (side_width[0] == '0) || (side_width[1] == '0);

        case (seq_q.state)
            ST_IDLE: begin
                if (start_req && mode_en) begin
                    if (empty_job) begin
                        irq_set = 1'b1;
                    end else begin
                        seq_d.state = ST_RUN;
                        seq_d.left  = count;
                        cur_load    = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                mem_rd_en     = 1'b1;
                cur_step      = 1'b1;
                seq_d.wr_en   = 1'b1;
                seq_d.wr_addr = side_addr[1];
                for (int i = 0; i < BEAT_BYTES; i++) begin
                    seq_d.wr_strb[i] = (32'(i) < seq_q.left);
                end
                if (seq_q.left <= 32'(BEAT_BYTES)) begin
                    seq_d.left  = '0;
                    seq_d.state = ST_DRAIN;
                end else begin
                    seq_d.left  = seq_q.left - 32'(BEAT_BYTES);
                end
            end
            ST_DRAIN: begin
                seq_d.state = ST_IDLE;
                irq_set     = 1'b1;
            end
            default: seq_d.state = ST_IDLE;
        endcase

        if (irq_set)      seq_d.irq = 1'b1;
        else if (irq_clr) seq_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: ST_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

    assign busy        = (seq_q.state != ST_IDLE);
    assign irq         = seq_q.irq;
    assign mem_rd_addr = side_addr[0];
    assign mem_wr_en   = seq_q.wr_en;
    assign mem_wr_addr = seq_q.wr_addr;
    assign mem_wr_strb = seq_q.wr_strb;
    assign mem_wr_data = mem_rd_data;

    // R3
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(mem_rd_en));

    // R7
    rd_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> busy);

    // R6
    start_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_we && reg_addr == REG_AW'(OFS_START)));

    // R8
    done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq);

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    // R5
    strb_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> mem_wr_strb[0]);

endmodule

// File: tb/strided_copy_engine_bench.sv
`timescale 1ns/1ps
module strided_copy_engine_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic         busy, irq;
    logic         mem_rd_en, mem_wr_en;
    logic [31:0]  mem_rd_addr, mem_wr_addr;
    logic [127:0] mem_rd_data, mem_wr_data;
    logic [15:0]  mem_wr_strb;

    always #2.5 clk = ~clk;

    strided_copy_engine u_strided_copy_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .busy(busy), .irq(irq),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_strb(mem_wr_strb)
    );

    logic [7:0] mem     [0:4095];
    logic [7:0] ref_mem [0:4095];
    int exp_rd_q[$];
    int exp_wr_q[$];
    int exp_strb_q[$];
    int n_chk = 0;
    int n_fail = 0;
    logic prev_rd = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // memory model: one-cycle read latency, byte-strobed writes
    always @(posedge clk) begin
        if (mem_rd_en)
            for (int b = 0; b < 16; b++) mem_rd_data[b*8 +: 8] <= mem[12'(mem_rd_addr + 32'(b))];
        if (mem_wr_en)
            for (int b = 0; b < 16; b++)
                if (mem_wr_strb[b]) mem[12'(mem_wr_addr + 32'(b))] <= mem_wr_data[b*8 +: 8];
    end

    // per-clock comparison against the expected transaction queues
    always @(negedge clk) begin
        int e;
        if (rst_n) begin
            chk(mem_wr_en == prev_rd, "R3", "write one cycle after read", mem_wr_en, prev_rd);
            if (mem_rd_en) begin
                if (exp_rd_q.size() == 0) chk(0, "R7", "unexpected read", mem_rd_addr, 0);
                else begin
                    e = exp_rd_q.pop_front();
                    chk(mem_rd_addr == 32'(e), "R4", "read address", mem_rd_addr, e);
                end
            end
            if (mem_wr_en) begin
                if (exp_wr_q.size() == 0) chk(0, "R7", "unexpected write", mem_wr_addr, 0);
                else begin
                    e = exp_wr_q.pop_front();
                    chk(mem_wr_addr == 32'(e), "R4", "write address", mem_wr_addr, e);
                    e = exp_strb_q.pop_front();
                    chk(mem_wr_strb == 16'(e), "R5", "write strobe", mem_wr_strb, e);
                end
            end
        end
        prev_rd = rst_n ? mem_rd_en : 1'b0;
    end

    task automatic reg_write(input int ofs, input int val);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'(ofs); reg_wdata = 32'(val);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // byte-level model of the strided copy; beats start at every 16th byte
    task automatic ref_copy(input int s0, input int d0, input int size,
                            input int iw, input int ig, input int ow, input int og);
        int s = s0, d = d0, ri = iw, ro = ow;
        for (int n = 0; n < size; n++) begin
            if (n % 16 == 0) begin
                exp_rd_q.push_back(s);
                exp_wr_q.push_back(d);
                exp_strb_q.push_back((size - n >= 16) ? 32'hFFFF : ((1 << (size - n)) - 1));
            end
            ref_mem[d & 4095] = ref_mem[s & 4095];
            s++; d++; ri--; ro--;
            if (ri == 0) begin ri = iw; s += ig; end
            if (ro == 0) begin ro = ow; d += og; end
        end
    endtask

    task automatic run_copy(input string name, input int sword, input int dword, input int size,
                            input int siw, input int sig, input int dow, input int dog,
                            input bit retrig);
        bit   zero = (size == 0) || (siw == 0) || (dow == 0);
        logic last_wr = 1'b0;
        int   guard = 0;
        int   bad = 0;
        reg_write(0, sword);
        reg_write(1, dword);
        reg_write(2, size);
        reg_write(3, (sig << 16) | siw);
        reg_write(4, (dog << 16) | dow);
        reg_write(5, 32'h8);
        if (!zero) ref_copy(sword * 8, dword * 8, size, siw * 16, sig * 16, dow * 16, dog * 16);
        reg_write(6, 1);
        if (zero) begin
            chk(busy == 1'b0, "R9", {name, " busy stays low"}, busy, 0);
            chk(irq == 1'b1, "R9", {name, " irq on accept"}, irq, 1);
            repeat (5) @(negedge clk);
            chk(irq == 1'b1 && busy == 1'b0, "R9", {name, " settled"}, {irq, busy}, 2'b10);
        end else begin
            chk(busy == 1'b1, "R7", {name, " busy after start"}, busy, 1);
            if (retrig) reg_write(6, 1);
            while (busy && guard < 4000) begin
                last_wr = mem_wr_en;
                @(negedge clk);
                guard++;
            end
            chk(irq == 1'b1, "R8", {name, " irq with busy fall"}, irq, 1);
            chk(last_wr == 1'b1, "R8", {name, " final write just before done"}, last_wr, 1);
            chk(exp_rd_q.size() == 0 && exp_wr_q.size() == 0, "R5", {name, " beats left over"},
                exp_rd_q.size() + exp_wr_q.size(), 0);
            for (int i = 0; i < 4096; i++) if (mem[i] !== ref_mem[i]) bad++;
            chk(bad == 0, "R4", {name, " memory bytes differing"}, bad, 0);
        end
        reg_write(7, 1);
        chk(irq == 1'b0, "R10", {name, " irq cleared"}, irq, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) begin
            mem[i] = 8'(i * 7 + 3);
            ref_mem[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11
        chk({busy, irq, mem_rd_en, mem_wr_en} == 4'b0, "R11", "reset outputs",
            {busy, irq, mem_rd_en, mem_wr_en}, 0);

        // R1 R2 R4: equal geometry with gaps
        run_copy("same_geom", 32'h20, 32'h100, 96, 2, 1, 2, 1, 1'b0);
        // R4 R7: mismatched rows, 8-byte aligned source, restart while busy ignored
        run_copy("repack", 32'h48, 32'h130, 160, 3, 0, 1, 2, 1'b1);
        // R5: partial last beat
        run_copy("partial", 32'h40, 32'h1A0, 40, 1, 1, 4, 0, 1'b0);
        // R4: longer job, uneven rows on both sides
        run_copy("long", 32'h0, 32'h80, 512, 5, 3, 7, 1, 1'b0);
        // R9: degenerate jobs
        run_copy("zero_count", 32'h10, 32'h30, 0, 2, 0, 2, 0, 1'b0);
        run_copy("zero_src_w", 32'h10, 32'h30, 64, 0, 1, 2, 0, 1'b0);
        run_copy("zero_dst_w", 32'h10, 32'h30, 64, 2, 1, 0, 1, 1'b0);

        // R6: start ignored without control bit 3
        reg_write(2, 64);
        reg_write(3, 2);
        reg_write(4, 2);
        reg_write(5, 32'hF7);
        reg_write(6, 1);
        repeat (10) @(negedge clk);
        chk(busy == 1'b0, "R6", "no start without mode bit", busy, 0);
        chk(irq == 1'b0, "R6", "no irq without mode bit", irq, 0);

        // R10: clear only with bit 0
        reg_write(2, 0);
        reg_write(5, 32'h8);
        reg_write(6, 1);
        chk(irq == 1'b1, "R10", "irq set by empty job", irq, 1);
        reg_write(7, 0);
        chk(irq == 1'b1, "R10", "status write of 0 keeps irq", irq, 1);
        reg_write(7, 2);
        chk(irq == 1'b1, "R10", "status bit 1 keeps irq", irq, 1);
        reg_write(7, 1);
        chk(irq == 1'b0, "R10", "status bit 0 clears irq", irq, 0);

        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule